// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serial Shifter

This block turns a parallel word into a serial bit stream. It holds a chain of eight stages, named A (first) through H (last). While the active-low load control is low, every stage takes its parallel input on each system clock. While the control is high, a rising edge of the combined shift clock moves the chain one place toward H, and stage A takes the serial input. Stage H is presented on two outputs, one true and one inverted.

The shift clock is formed from two gate inputs that play the same role. The combined clock is their OR. Holding either gate high blocks the other, and holding one low lets the other act as the clock. Everything runs in one synchronous system-clock domain. The gate inputs are sampled as ordinary data, and a rising edge of their OR is detected from one sample to the next. A shift takes effect on the second system clock edge after the gate input rises. A typical use is to load a byte and then feed a slow external shift clock on one gate, while a firmware-driven enable drives the other gate as an inhibit.

Top module: `piso_shifter`

## Requirements
- R1: Parallel input bit i feeds stage i, with stage A at bit 0 and stage H at bit WIDTH-1. After a load, `lastOut` equals `parIn[WIDTH-1]`.
- R2: While `loadN` is low, every system clock edge copies `parIn` into all stages, whatever the levels on `gateA`, `gateB` and `serialIn`.
- R3: Load wins over shifting. While `loadN` is high, changes on `parIn` do not change the stages.
- R4: With `loadN` high, a rising edge of (`gateA` OR `gateB`) gives exactly one shift. Stage A takes `serialIn` and every other stage takes the old value of the stage before it. The shift is visible after the second system clock edge following the rise of the gate input.
- R5: While one gate input is held high, pulses on the other cause no shift. Raising the inhibiting gate while the clocking gate is high causes no shift.
- R6: While both gate inputs stay at steady levels and `loadN` is high, all stages hold their values.
- R7: `lastOutN` is always the inverse of `lastOut`.
- R8: A synchronous active-high `rst` clears all stages (so `lastOut`=0 and `lastOutN`=1) and clears the gate sample history.
- R9: After a load of value v and WIDTH shift edges, `lastOut` has presented v[WIDTH-1], v[WIDTH-2], ..., v[0] in that order. Each bit is present before the shift edge that follows it, and the serial input bits follow them out in the order they were shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Active-low level load control |
| gateA | input | 1 | Shift clock gate input, interchangeable with gateB |
| gateB | input | 1 | Shift clock gate input, interchangeable with gateA |
| serialIn | input | 1 | Serial data entering stage A |
| parIn | input | WIDTH | Parallel data, bit 0 to stage A |
| lastOut | output | 1 | Stage H value |
| lastOutN | output | 1 | Inverse of stage H |

## Verification
The hardest case to reach from the ports is a rising gate edge that must be ignored. This happens when one gate is already high, or when the inhibiting gate rises on top of an active clock. It only shows up when the bench drives the documented inhibit sequence in the right order: raise the clock gate, raise the inhibit, pulse the clock gate underneath it, then release the inhibit while the clock is high. The bench mixes that directed sequence, loads with gate activity during the load, and a mid-run reset into a seeded random stream of loads, shifts through either gate, idle gaps and parallel-input changes. A bench model of the stage chain predicts every `lastOut` value, and a load followed by a full eight-edge drain checks the serial order.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    loadN,
  input  logic    gateA,
  input  logic    gateB,
  output strobe_t strb
);
  logic syncA, syncB, orPrev, orNow;

  assign orNow = syncA | syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      orPrev <= 1'b0;
    end else begin
      syncA  <= gateA;
      syncB  <= gateB;
      orPrev <= orNow;
    end
  end

  always_comb begin
    strb.load  = ~loadN;
    strb.shift = loadN & orNow & ~orPrev;
  end

  // A shift strobe lasts one cycle per gate edge (R4)
  assert_single_shift_R4: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> !strb.shift);

  // A shift strobe traces back to a rise of the sampled gate OR (R4, R5)
  assert_edge_origin_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !$past(rst) && !$past(rst, 2)) |->
      ($past(gateA || gateB) && !$past(gateA || gateB, 2)));

  // Load and shift strobes never coincide (R3)
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.shift}));
endmodule

// File: rtl/shifter_path.sv
module shifter_path
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stageNext;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : gen_stage
      logic shiftSrc;
      if (g == 0) begin : gen_head
        assign shiftSrc = serialIn;
      end else begin : gen_body
        assign shiftSrc = stageQ[g-1];
      end
      always_comb begin
        if (strb.load)       stageNext[g] = parIn[g];
        else if (strb.shift) stageNext[g] = shiftSrc;
        else                 stageNext[g] = stageQ[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stageQ <= '0;
    else     stageQ <= stageNext;
  end

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (stageQ == $past(parIn)));

  assert_shift_move_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !strb.load) |=>
      (stageQ == {$past(stageQ[LAST-1:0]), $past(serialIn)}));

  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.shift) |=> $stable(stageQ));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (stageQ == '0));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic             gateA,
  input  logic             gateB,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             lastOut,
  output logic             lastOutN
);
  strobe_t          strb;
  logic [WIDTH-1:0] stageQ;

  shifter_ctrl i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .loadN (loadN),
    .gateA (gateA),
    .gateB (gateB),
    .strb  (strb)
  );

  shifter_path #(.WIDTH(WIDTH)) i_path (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .serialIn (serialIn),
    .parIn    (parIn),
    .stageQ   (stageQ)
  );

  // Stage H in true and inverted form (R1, R7)
  assign lastOut  = stageQ[WIDTH-1];
  assign lastOutN = ~stageQ[WIDTH-1];
endmodule

// File: tb/test_piso_shifter.sv
module test_piso_shifter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadN = 1'b1;
  logic gateA = 1'b0;
  logic gateB = 1'b0;
  logic serialIn = 1'b0;
  logic [W-1:0] parIn = '0;
  logic lastOut, lastOutN;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] expQ = '0;

  always #10 clk = ~clk;

  piso_shifter #(.WIDTH(W)) i_piso_shifter (
    .clk(clk), .rst(rst), .loadN(loadN), .gateA(gateA), .gateB(gateB),
    .serialIn(serialIn), .parIn(parIn), .lastOut(lastOut), .lastOutN(lastOutN)
  );

  function automatic logic [W-1:0] modelShift(logic [W-1:0] q, logic s);
    return {q[W-2:0], s};
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(string req);
    check(req, lastOut, expQ[W-1]);
    check("R7", lastOutN, ~lastOut);
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(logic [W-1:0] v, bit wiggle);
    loadN = 1'b0;
    parIn = ~v;
    serialIn = 1'b1;
    if (wiggle) begin
      gateA = 1'b1; waitN(3); gateA = 1'b0; waitN(3);
      gateB = 1'b1; waitN(3); gateB = 1'b0; waitN(3);
    end else waitN(1);
    parIn = v;
    waitN(1);
    loadN = 1'b1;
    expQ = v;
    waitN(1);
  endtask

  task automatic doEdge(bit useB, logic s);
    serialIn = s;
    if (useB) gateB = 1'b1; else gateA = 1'b1;
    waitN(3);
    if (useB) gateB = 1'b0; else gateA = 1'b0;
    waitN(2);
    expQ = modelShift(expQ, s);
  endtask

  // Clock high, inhibit raised, clock pulsed under inhibit, inhibit released
  // while clock high: only the first rise counts.
  task automatic doInhibited(logic s);
    serialIn = s;
    gateA = 1'b1; waitN(3);
    expQ = modelShift(expQ, s);
    gateB = 1'b1; waitN(3);
    gateA = 1'b0; waitN(3);
    serialIn = ~s;
    gateA = 1'b1; waitN(3);
    gateA = 1'b0; waitN(3);
    gateA = 1'b1; waitN(3);
    gateB = 1'b0; waitN(3);
    gateA = 1'b0; waitN(3);
  endtask

  initial begin
    waitN(20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5a17);
    waitN(3);
    rst = 1'b0;
    waitN(1);
    checkOut("R8");

    // R1 / R9: load then drain in order through gate A
    doLoad(8'b1011_0010, 1'b0);
    check("R1", lastOut, 1'b1);
    for (int i = W - 1; i >= 0; i--) begin
      check("R9", lastOut, (8'b1011_0010 >> i) & 1'b1);
      doEdge(1'b0, 1'(i & 1));
    end
    checkOut("R9");

    // R2: load with gate activity during the load
    doLoad(8'h6C, 1'b1);
    checkOut("R2");
    doEdge(1'b1, 1'b0);
    checkOut("R4");
    doEdge(1'b1, 1'b1);
    checkOut("R4");

    // R3: parallel inputs ignored while loadN high
    parIn = 8'hFF; waitN(4);
    checkOut("R3");
    parIn = 8'h00; waitN(4);
    checkOut("R3");

    // R5: inhibit sequence
    doLoad(8'hA5, 1'b0);
    doInhibited(1'b0);
    checkOut("R5");
    for (int i = 0; i < W; i++) begin
      doEdge(1'b0, 1'b1);
      checkOut("R5");
    end

    // R6: steady gates hold, including one held high
    gateB = 1'b1; waitN(3);
    expQ = modelShift(expQ, serialIn);
    serialIn = 1'b0; waitN(6);
    checkOut("R6");
    gateB = 1'b0; waitN(6);
    checkOut("R6");

    // R8: reset mid-run
    doLoad(8'hFF, 1'b0);
    rst = 1'b1; waitN(2); rst = 1'b0; waitN(1);
    expQ = '0;
    checkOut("R8");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: doLoad(W'($urandom), 1'($urandom_range(0, 1)));
        1: doEdge(1'b0, 1'($urandom_range(0, 1)));
        2: doEdge(1'b1, 1'($urandom_range(0, 1)));
        3: doInhibited(1'($urandom_range(0, 1)));
        4: begin parIn = W'($urandom); waitN(3); end
        default: waitN($urandom_range(1, 5));
      endcase
      checkOut("R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule